// File: doc/BRIEF.md
# Interrupt-Pending CSR Unit with Virtual-Supervisor Aliasing

This block keeps the machine interrupt-pending state and the hypervisor virtual interrupt-pending state of one hart that has the hypervisor extension and local counter-overflow interrupts. It handles the aliasing between the two registers when they are read and written over a single-cycle CSR port. Reads are combinational from the address. A write lands on the next rising clock edge.

The unit merges hardware interrupt levels into the machine view and ANDs that view with the interrupt-enable vector, which is supplied from elsewhere, to produce the pending-and-enabled candidates. It also rewrites the cause code of an interrupt that is being delivered to a virtual-supervisor guest into the code that the guest sees. The CSR numbers are the standard ones: machine pending at 0x344 and hypervisor virtual pending at 0x645. The interrupt bit positions are also standard: SSIP 1, VSSIP 2, STIP 5, VSTIP 6, SEIP 9, VSEIP 10, SGEIP 12, LCOFIP 13.

Top module: `hip_csr_unit`

## Requirements
- R1: While reset is asserted and after it is released, both registers read zero when the hardware levels are low, and the pending-and-enabled output is zero.
- R2: A write to 0x344 updates only bits 1, 2, 5, 9 and 13 (bit 13 only when counter-overflow support is on) on the next edge. All other bits of that write are ignored, and those bits read zero unless another source drives them.
- R3: A read of 0x344 returns the stored machine bits ORed with hvip bits 6 and 10 only. An hvip bit 13 never appears in the 0x344 read value.
- R4: Bit 2 is one shared bit. A read of 0x645 shows it, and a write to 0x645 updates it, so the new value is visible at 0x344 after the next edge.
- R5: A write to 0x645 stores bits 6 and 10, and stores bit 13 when counter-overflow support is on. With that support off, bit 13 reads zero and writes to it are discarded. Every other hvip bit reads zero.
- R6: The input hw_sei_i sets bit 9 and the input hw_sgei_i sets bit 12 of the 0x344 read value. Bit 12, and bits 6 and 10, cannot be written through 0x344.
- R7: pend_en_o equals the 0x344 read value ANDed with mie_i, bit for bit.
- R8: When trap_vs_i is high, cause codes 2, 6 and 10 are reported as 1, 5 and 9.
- R9: When trap_vs_i is high, cause code 12 is reported as 9.
- R10: Cause code 13 is reported unchanged. Every code not named in R8 or R9 is also unchanged, and when trap_vs_i is low every code passes through unchanged.
- R11: A read of any other address returns zero. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR number for the access |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write strobe; committed on the next rising edge |
| csr_rdata_o | output | XLEN | Combinational read data for csr_addr_i |
| hw_sei_i | input | 1 | Supervisor external interrupt level |
| hw_sgei_i | input | 1 | Supervisor guest-external interrupt level |
| mie_i | input | XLEN | Interrupt-enable vector |
| pend_en_o | output | XLEN | Pending and enabled interrupt candidates |
| trap_vs_i | input | 1 | Interrupt is being delivered to virtual-supervisor mode |
| trap_code_i | input | CW | Raw interrupt cause code |
| trap_code_o | output | CW | Cause code as reported |

## Verification
The hardest case to reach is an hvip bit 13 that is set while the stored machine bit 13 is clear, because a leak into the machine view shows only in that state. A full-ones write to the machine register followed by a full-ones write to hvip does not produce it. The vector walk therefore clears the machine register after hvip has been filled, and then writes hvip with bit 13 alone. The bench checks the shared bit 2 the same way: it writes through one register and reads through the other. A second instance with counter-overflow support turned off covers the discarded-write variant.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int IPW = 16;

  localparam int B_SSI  = 1;
  localparam int B_VSSI = 2;
  localparam int B_STI  = 5;
  localparam int B_VSTI = 6;
  localparam int B_SEI  = 9;
  localparam int B_VSEI = 10;
  localparam int B_SGEI = 12;
  localparam int B_LCOF = 13;

  localparam logic [11:0] ADDR_MIP  = 12'h344;
  localparam logic [11:0] ADDR_HVIP = 12'h645;

  localparam logic [IPW-1:0] M_SSI  = IPW'(1) << B_SSI;
  localparam logic [IPW-1:0] M_VSSI = IPW'(1) << B_VSSI;
  localparam logic [IPW-1:0] M_STI  = IPW'(1) << B_STI;
  localparam logic [IPW-1:0] M_VSTI = IPW'(1) << B_VSTI;
  localparam logic [IPW-1:0] M_SEI  = IPW'(1) << B_SEI;
  localparam logic [IPW-1:0] M_VSEI = IPW'(1) << B_VSEI;
  localparam logic [IPW-1:0] M_SGEI = IPW'(1) << B_SGEI;
  localparam logic [IPW-1:0] M_LCOF = IPW'(1) << B_LCOF;
endpackage

// File: rtl/hip_store.sv
module hip_store
  import hip_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit HAS_LCOF = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_mip_i,
  input  logic            wr_hvip_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mip_q_o,
  output logic [XLEN-1:0] hvip_q_o
);
  localparam logic [IPW-1:0] LCOF_M = HAS_LCOF ? M_LCOF : '0;
  localparam logic [XLEN-1:0] MIP_WM  = XLEN'(M_SSI | M_VSSI | M_STI | M_SEI | LCOF_M);
  localparam logic [XLEN-1:0] HVIP_WM = XLEN'(M_VSTI | M_VSEI | LCOF_M);

  logic [XLEN-1:0] mip_q, mip_d, hvip_q, hvip_d;
  logic            upd_en;

  // next-state
  always_comb begin
    mip_d  = mip_q;
    hvip_d = hvip_q;
    if (wr_mip_i) begin
      mip_d = (mip_q & ~MIP_WM) | (wdata_i & MIP_WM);
    end
    if (wr_hvip_i) begin
      hvip_d         = wdata_i & HVIP_WM;
      mip_d[B_VSSI]  = wdata_i[B_VSSI];
    end
  end

  assign upd_en = wr_mip_i | wr_hvip_i;

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q  <= '0;
      hvip_q <= '0;
    end else if (upd_en) begin
      mip_q  <= mip_d;
      hvip_q <= hvip_d;
    end
  end

  assign mip_q_o  = mip_q;
  assign hvip_q_o = hvip_q;

  // Shared bit 2 follows a write through the hypervisor view
  assert_vssip_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hvip_i |=> (mip_q[B_VSSI] == $past(wdata_i[B_VSSI])));

  // No write strobe, no change in either register
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_mip_i || wr_hvip_i) |=> ($stable(mip_q) && $stable(hvip_q)));
endmodule

// File: rtl/hip_view.sv
module hip_view
  import hip_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] mip_q_i,
  input  logic [XLEN-1:0] hvip_q_i,
  input  logic            hw_sei_i,
  input  logic            hw_sgei_i,
  input  logic [XLEN-1:0] mie_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] pend_o
);
  localparam logic [XLEN-1:0] HV_TO_M = XLEN'(M_VSTI | M_VSEI);
  localparam logic [XLEN-1:0] VSSI_X  = XLEN'(M_VSSI);
  localparam logic [XLEN-1:0] SEI_X   = XLEN'(M_SEI);
  localparam logic [XLEN-1:0] SGEI_X  = XLEN'(M_SGEI);

  logic [XLEN-1:0] mip_eff, hvip_eff;

  always_comb begin
    mip_eff = mip_q_i | (hvip_q_i & HV_TO_M);
    if (hw_sei_i)  mip_eff = mip_eff | SEI_X;
    if (hw_sgei_i) mip_eff = mip_eff | SGEI_X;
    hvip_eff = hvip_q_i | (mip_q_i & VSSI_X);
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MIP:  rdata_o = mip_eff;
      ADDR_HVIP: rdata_o = hvip_eff;
      default:   rdata_o = '0;
    endcase
  end

  assign pend_o = mip_eff & mie_i;

  // Nothing reported pending that is not enabled
  assert_pend_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~mie_i) == '0);

  // An external level always surfaces in the machine view
  assert_sei_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_sei_i && addr_i == ADDR_MIP) |-> rdata_o[B_SEI]);
endmodule

// File: rtl/hip_cause_xlate.sv
module hip_cause_xlate
  import hip_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vs_i,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = code_i;
    if (vs_i) begin
      if (code_i == CW'(B_VSSI) || code_i == CW'(B_VSTI) || code_i == CW'(B_VSEI)) begin
        code_o = code_i - CW'(1);
      end else if (code_i == CW'(B_SGEI)) begin
        code_o = CW'(B_SEI);
      end
    end
  end

  assert_sgei_as_sei_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_i && code_i == CW'(B_SGEI)) |-> (code_o == CW'(B_SEI)));

  assert_lcof_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == CW'(B_LCOF)) |-> (code_o == CW'(B_LCOF)));
endmodule

// File: rtl/hip_csr_unit.sv
module hip_csr_unit
  import hip_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit HAS_LCOF = 1'b1,
  parameter int CW       = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            csr_we_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            hw_sei_i,
  input  logic            hw_sgei_i,
  input  logic [XLEN-1:0] mie_i,
  output logic [XLEN-1:0] pend_en_o,
  input  logic            trap_vs_i,
  input  logic [CW-1:0]   trap_code_i,
  output logic [CW-1:0]   trap_code_o
);
  logic            wr_mip, wr_hvip;
  logic [XLEN-1:0] mip_q, hvip_q;

  assign wr_mip  = csr_we_i && (csr_addr_i == ADDR_MIP);
  assign wr_hvip = csr_we_i && (csr_addr_i == ADDR_HVIP);

  hip_store #(.XLEN(XLEN), .HAS_LCOF(HAS_LCOF)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mip_i  (wr_mip),
    .wr_hvip_i (wr_hvip),
    .wdata_i   (csr_wdata_i),
    .mip_q_o   (mip_q),
    .hvip_q_o  (hvip_q)
  );

  hip_view #(.XLEN(XLEN)) u_view (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (csr_addr_i),
    .mip_q_i   (mip_q),
    .hvip_q_i  (hvip_q),
    .hw_sei_i  (hw_sei_i),
    .hw_sgei_i (hw_sgei_i),
    .mie_i     (mie_i),
    .rdata_o   (csr_rdata_o),
    .pend_o    (pend_en_o)
  );

  hip_cause_xlate #(.CW(CW)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vs_i   (trap_vs_i),
    .code_i (trap_code_i),
    .code_o (trap_code_o)
  );

  // hvip counter-overflow bit must not reach the machine view
  assert_no_lcof_leak_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == ADDR_MIP && !mip_q[B_LCOF]) |-> !csr_rdata_o[B_LCOF]);
endmodule

// File: tb/hip_csr_unit_tb.sv
module hip_csr_unit_tb;
  localparam int XLEN = 64;
  localparam int CW   = 6;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata;
  logic            csr_we;
  logic [XLEN-1:0] rdata, rdata_nl;
  logic            hw_sei, hw_sgei;
  logic [XLEN-1:0] mie, pend, pend_nl;
  logic            trap_vs;
  logic [CW-1:0]   code_in, code_out, code_out_nl;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hip_csr_unit #(.XLEN(XLEN), .HAS_LCOF(1'b1), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_rdata_o(rdata), .hw_sei_i(hw_sei), .hw_sgei_i(hw_sgei),
    .mie_i(mie), .pend_en_o(pend), .trap_vs_i(trap_vs), .trap_code_i(code_in),
    .trap_code_o(code_out)
  );

  hip_csr_unit #(.XLEN(XLEN), .HAS_LCOF(1'b0), .CW(CW)) u_dut_nl (
    .clk_i(clk), .rst_ni(rst_ni), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_rdata_o(rdata_nl), .hw_sei_i(hw_sei), .hw_sgei_i(hw_sgei),
    .mie_i(mie), .pend_en_o(pend_nl), .trap_vs_i(trap_vs), .trap_code_i(code_in),
    .trap_code_o(code_out_nl)
  );

  // {addr, wdata, expected 0x344 read, expected 0x645 read}
  localparam logic [59:0] VEC [0:7] = '{
    {12'h344, 16'hFFFF, 16'h2226, 16'h0004},
    {12'h645, 16'hFFFF, 16'h2666, 16'h2444},
    {12'h344, 16'h0000, 16'h0440, 16'h2440},
    {12'h645, 16'h0004, 16'h0004, 16'h0004},
    {12'h645, 16'h2000, 16'h0000, 16'h2000},
    {12'h344, 16'h1440, 16'h0000, 16'h2000},
    {12'h300, 16'hFFFF, 16'h0000, 16'h2000},
    {12'h645, 16'h0040, 16'h0040, 16'h0040}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    csr_addr  = a;
    csr_wdata = XLEN'(d);
    csr_we    = 1'b1;
    @(negedge clk);
    csr_we    = 1'b0;
  endtask

  task automatic read_at(input logic [11:0] a, output logic [63:0] v, output logic [63:0] v_nl);
    csr_addr = a;
    #1;
    v    = rdata;
    v_nl = rdata_nl;
  endtask

  function automatic logic [CW-1:0] exp_code(input logic vs, input logic [CW-1:0] c);
    if (!vs) return c;
    case (c)
      CW'(2), CW'(6), CW'(10): return c - CW'(1);
      CW'(12):                 return CW'(9);
      default:                 return c;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v, vn;
    rst_ni = 1'b0; csr_addr = 12'h344; csr_wdata = '0; csr_we = 1'b0;
    hw_sei = 1'b0; hw_sgei = 1'b0; mie = '1; trap_vs = 1'b0; code_in = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    read_at(12'h344, v, vn); check("R1 mip in reset", v, 64'h0);
    check("R1 pend in reset", pend, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_at(12'h344, v, vn); check("R1 mip after reset", v, 64'h0);
    read_at(12'h645, v, vn); check("R1 hvip after reset", v, 64'h0);
    check("R1 pend after reset", pend, 64'h0);

    // vector walk: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][59:48], VEC[i][47:32]);
      read_at(12'h344, v, vn);
      check($sformatf("R2/R3/R4/R6 mip vec %0d", i), v, 64'(VEC[i][31:16]));
      read_at(12'h645, v, vn);
      check($sformatf("R4/R5/R11 hvip vec %0d", i), v, 64'(VEC[i][15:0]));
    end

    // R11: unmapped read
    read_at(12'h300, v, vn); check("R11 unmapped read", v, 64'h0);

    // R6 hardware levels, R7 pending
    hw_sei = 1'b1; hw_sgei = 1'b1; mie = '1;
    read_at(12'h344, v, vn); check("R6 hw levels in mip", v, 64'h1240);
    check("R7 pend all enabled", pend, 64'h1240);
    mie = 64'h0040;
    #1; check("R7 pend masked", pend, 64'h0040);
    mie = 64'h1000;
    #1; check("R7 pend sgei only", pend, 64'h1000);
    do_write(12'h344, 16'h0200);
    hw_sei = 1'b0; hw_sgei = 1'b0; mie = '1;
    read_at(12'h344, v, vn); check("R6 software SEIP held", v, 64'h0240);
    check("R7 pend after drop", pend, 64'h0240);

    // R5: variant without counter-overflow support
    do_write(12'h645, 16'hFFFF);
    read_at(12'h645, v, vn); check("R5 hvip no-lcof variant", vn, 64'h0444);
    do_write(12'h344, 16'hFFFF);
    read_at(12'h344, v, vn); check("R2 mip no-lcof variant", vn, 64'h0666);

    // R8 R9 R10 cause translation
    for (int vs = 0; vs < 2; vs++) begin
      for (int c = 0; c < 16; c++) begin
        trap_vs = vs[0];
        code_in = CW'(c);
        #1;
        check($sformatf("R8/R9/R10 cause vs=%0d code=%0d", vs, c),
              64'(code_out), 64'(exp_code(vs[0], CW'(c))));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule